// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block holds the program counter of a simple in-order core as a pair of registers: the address of the instruction being executed (`fetch_pc`) and the address that follows it (`next_pc`). Each time the core retires an instruction (`step` high for one clock), the sequencer moves `next_pc` into `fetch_pc`. It then computes the new `next_pc` from the decoded control-transfer kind of the retiring instruction. A transfer only ever rewrites `next_pc`, so the one instruction after any branch or jump, the delay slot, always runs before control reaches the target.

Branch decisions come straight from register values: two operands are compared for equality or inequality, or the first operand is tested against zero as a signed number. No condition flags exist. Conditional branch targets are relative to the delay-slot address. Absolute jumps splice a 26-bit word index under the top bits of the delay-slot address. Register jumps take a full address from an operand. The link forms request a write of the return address (the transfer's own address plus 8) into link register 31, one cycle after the step.

Top module: `dslot_pc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc` becomes RESET_VEC (default 0x0000_1000), `next_pc` becomes RESET_VEC+4 and `link_we` becomes 0.
- R2: A step with `xfer_kind` 0 (no transfer) loads `fetch_pc` with the old `next_pc` and loads `next_pc` with the old `next_pc`+4.
- R3: A taken conditional branch loads `fetch_pc` with the old `next_pc` (the delay slot) and loads `next_pc` with the old `next_pc` plus the sign-extended `br_off` shifted left by 2. The following step therefore fetches the target.
- R4: A conditional branch that is not taken behaves exactly as R2.
- R5: Kind 1 is taken when `opnd_a`==`opnd_b`. Kind 2 is taken when they differ.
- R6: `opnd_a` is compared with zero as a signed number. Kind 3 is taken when it is <=0, kind 4 when it is >0, kinds 5 and 7 when it is <0, and kinds 6 and 8 when it is >=0.
- R7: Kinds 9 (jump) and 10 (jump with link) load `next_pc` with {old `next_pc`[31:28], `jmp_idx`, 2'b00}.
- R8: Kind 11 (register jump) loads `next_pc` with `reg_tgt`.
- R9: For a step with kind 7, 8 or 10, `link_we` is high in the following cycle and `link_val` equals the transfer's `fetch_pc`+8, whether or not the branch is taken. `link_idx` is always 31. For any other step, or no step, `link_we` is low in the following cycle.
- R10: Kinds 12 to 15 behave as kind 0.
- R11: With `step` low, `fetch_pc` and `next_pc` hold their values and `link_we` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Current instruction retires this cycle |
| xfer_kind | input | 4 | Decoded control-transfer kind (see R2 to R10) |
| opnd_a | input | XLEN (32) | First compared register value |
| opnd_b | input | XLEN (32) | Second compared register value |
| br_off | input | OFF_W (16) | Branch word offset |
| jmp_idx | input | IDX_W (26) | Absolute jump word index |
| reg_tgt | input | XLEN (32) | Register jump target |
| fetch_pc | output | XLEN (32) | Address of the instruction now executing |
| next_pc | output | XLEN (32) | Address of the instruction that follows |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Link register number, constant 31 |
| link_val | output | XLEN (32) | Return address to write |

## Verification
The bench targets the delay slot. If a taken branch rewrote `fetch_pc` directly, the slot instruction would be skipped and the step after the branch would show the target one step early. The zero tests use 0, 0x8000_0000 and 0xFFFF_FFFF. These values expose a design that compares unsigned or mixes up the strict and non-strict forms. A negative offset catches a missing sign extension. A jump index with its top bit set, issued from a high address, catches a splice that drops the upper address bits. A link branch that is not taken must still raise `link_we`, with the value +8 rather than +4.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    XK_NONE   = 4'd0,
    XK_BEQ    = 4'd1,
    XK_BNE    = 4'd2,
    XK_BLEZ   = 4'd3,
    XK_BGTZ   = 4'd4,
    XK_BLTZ   = 4'd5,
    XK_BGEZ   = 4'd6,
    XK_BLTZL  = 4'd7,
    XK_BGEZL  = 4'd8,
    XK_JMP    = 4'd9,
    XK_JMPL   = 4'd10,
    XK_JREG   = 4'd11
  } xfer_e;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_REL  = 2'd1,
    SEL_ABS  = 2'd2,
    SEL_REG  = 2'd3
  } tgt_sel_e;

endpackage

// File: rtl/dslot_cond.sv
module dslot_cond
  import dslot_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  output tgt_sel_e          sel,
  output logic              do_link
);

  logic a_eq_b;
  logic a_neg;
  logic a_zero;
  logic taken;
  xfer_e k;

  assign k      = xfer_e'(kind);
  assign a_eq_b = (opnd_a == opnd_b);
  assign a_neg  = opnd_a[XLEN-1];
  assign a_zero = (opnd_a == '0);

  always_comb begin
    taken   = 1'b0;
    do_link = 1'b0;
    sel     = SEL_SEQ;
    case (k)
      XK_BEQ:   taken = a_eq_b;
      XK_BNE:   taken = !a_eq_b;
      XK_BLEZ:  taken = a_neg || a_zero;
      XK_BGTZ:  taken = !a_neg && !a_zero;
      XK_BLTZ:  taken = a_neg;
      XK_BGEZ:  taken = !a_neg;
      XK_BLTZL: begin taken = a_neg;  do_link = 1'b1; end
      XK_BGEZL: begin taken = !a_neg; do_link = 1'b1; end
      XK_JMP:   sel = SEL_ABS;
      XK_JMPL:  begin sel = SEL_ABS; do_link = 1'b1; end
      XK_JREG:  sel = SEL_REG;
      default:  sel = SEL_SEQ;
    endcase
    if (taken) sel = SEL_REL;
  end

endmodule

// File: rtl/dslot_tgt.sv
module dslot_tgt
  import dslot_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  slot_pc,
  input  logic [OFF_W-1:0] br_off,
  input  logic [IDX_W-1:0] jmp_idx,
  input  logic [XLEN-1:0]  reg_tgt,
  input  tgt_sel_e         sel,
  output logic [XLEN-1:0]  nxt
);

  localparam int EXT_W  = XLEN - OFF_W - 2;
  localparam int HI_W   = XLEN - IDX_W - 2;
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] abs_pc;
  logic [XLEN-1:0] disp;

  assign disp   = {{EXT_W{br_off[OFF_W-1]}}, br_off, 2'b00};
  assign seq_pc = slot_pc + WORD;
  assign rel_pc = slot_pc + disp;
  assign abs_pc = {slot_pc[XLEN-1 -: HI_W], jmp_idx, 2'b00};

  always_comb begin
    case (sel)
      SEL_REL: nxt = rel_pc;
      SEL_ABS: nxt = abs_pc;
      SEL_REG: nxt = reg_tgt;
      default: nxt = seq_pc;
    endcase
  end

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
  import dslot_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              OFF_W     = 16,
  parameter int              IDX_W     = 26,
  parameter int              LREG_W    = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [KIND_W-1:0] xfer_kind,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [IDX_W-1:0]  jmp_idx,
  input  logic [XLEN-1:0]   reg_tgt,
  output logic [XLEN-1:0]   fetch_pc,
  output logic [XLEN-1:0]   next_pc,
  output logic              link_we,
  output logic [LREG_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val
);

  localparam logic [XLEN-1:0]   RET_SKIP = XLEN'(8);
  localparam logic [XLEN-1:0]   WORD     = XLEN'(4);
  localparam logic [LREG_W-1:0] LINK_REG = {LREG_W{1'b1}};

  tgt_sel_e        sel;
  logic            do_link;
  logic [XLEN-1:0] nxt;

  dslot_cond #(.XLEN(XLEN)) u_cond (
    .kind    (xfer_kind),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .sel     (sel),
    .do_link (do_link)
  );

  dslot_tgt #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
    .slot_pc (next_pc),
    .br_off  (br_off),
    .jmp_idx (jmp_idx),
    .reg_tgt (reg_tgt),
    .sel     (sel),
    .nxt     (nxt)
  );

  assign link_idx = LINK_REG;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= RESET_VEC;
      next_pc  <= RESET_VEC + WORD;
      link_we  <= 1'b0;
      link_val <= '0;
    end else begin
      link_we <= 1'b0;
      if (step) begin
        fetch_pc <= next_pc;
        next_pc  <= nxt;
        link_we  <= do_link;
        if (do_link) link_val <= fetch_pc + RET_SKIP;
      end
    end
  end

endmodule

// File: rtl/dslot_pc_seq_chk.sv
module dslot_pc_seq_chk
  import dslot_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic [KIND_W-1:0] xfer_kind,
  input logic [XLEN-1:0]   reg_tgt,
  input logic [XLEN-1:0]   fetch_pc,
  input logic [XLEN-1:0]   next_pc,
  input logic              link_we,
  input logic [XLEN-1:0]   link_val
);

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (fetch_pc == RESET_VEC && next_pc == RESET_VEC + XLEN'(4) && !link_we)); // R1

  AST_PC_TAKES_NEXT: assert property (@(posedge clk) disable iff (rst) step |=> fetch_pc == $past(next_pc)); // R2

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst) (step && xfer_kind == XK_NONE) |=> next_pc == $past(next_pc) + XLEN'(4)); // R2

  AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst) (step && xfer_kind == XK_JREG) |=> next_pc == $past(reg_tgt)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !step |=> ($stable(fetch_pc) && $stable(next_pc) && !link_we)); // R11

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst) (step && (xfer_kind == XK_JMPL || xfer_kind == XK_BLTZL || xfer_kind == XK_BGEZL)) |=> (link_we && link_val == $past(fetch_pc) + XLEN'(8))); // R9

endmodule

bind dslot_pc_seq dslot_pc_seq_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .xfer_kind (xfer_kind),
  .reg_tgt   (reg_tgt),
  .fetch_pc  (fetch_pc),
  .next_pc   (next_pc),
  .link_we   (link_we),
  .link_val  (link_val)
);

// File: tb/test_dslot_pc_seq.sv
`timescale 1ns/1ps
module test_dslot_pc_seq;

  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [3:0]  xfer_kind = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, reg_tgt = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_idx = '0;
  logic [31:0] fetch_pc, next_pc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] m_pc, m_npc;

  always #2.5 clk = ~clk;

  dslot_pc_seq i_dslot_pc_seq (
    .clk(clk), .rst(rst), .step(step), .xfer_kind(xfer_kind),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off), .jmp_idx(jmp_idx),
    .reg_tgt(reg_tgt), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
  );

  function automatic logic [31:0] ref_next(input logic [3:0] k, input logic [31:0] a, b,
                                           input logic [15:0] off, input logic [25:0] idx,
                                           input logic [31:0] tgt, input logic [31:0] slot);
    logic [31:0] seq, rel, jabs;
    seq  = slot + 32'd4;
    rel  = slot + {{14{off[15]}}, off, 2'b00};
    jabs = {slot[31:28], idx, 2'b00};
    case (k)
      4'd1:       return (a == b) ? rel : seq;
      4'd2:       return (a != b) ? rel : seq;
      4'd3:       return ($signed(a) <= 0) ? rel : seq;
      4'd4:       return ($signed(a) > 0) ? rel : seq;
      4'd5, 4'd7: return ($signed(a) < 0) ? rel : seq;
      4'd6, 4'd8: return ($signed(a) >= 0) ? rel : seq;
      4'd9, 4'd10: return jabs;
      4'd11:      return tgt;
      default:    return seq;
    endcase
  endfunction

  function automatic bit ref_link(input logic [3:0] k);
    return (k == 4'd7) || (k == 4'd8) || (k == 4'd10);
  endfunction

  function automatic string tag_of(input logic [3:0] k);
    case (k)
      4'd0:               return "R2";
      4'd1, 4'd2:         return "R5";
      4'd3, 4'd4, 4'd5, 4'd6: return "R6";
      4'd7, 4'd8, 4'd10:  return "R9";
      4'd9:               return "R7";
      4'd11:              return "R8";
      default:            return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_instr(input logic [3:0] k, input logic [31:0] a, b,
                           input logic [15:0] off, input logic [25:0] idx,
                           input logic [31:0] tgt, input bit stp, input string tag);
    logic [31:0] e_pc, e_npc, e_lval;
    bit e_lwe;
    xfer_kind = k; opnd_a = a; opnd_b = b; br_off = off; jmp_idx = idx;
    reg_tgt = tgt; step = stp;
    if (stp) begin
      e_pc   = m_npc;
      e_npc  = ref_next(k, a, b, off, idx, tgt, m_npc);
      e_lwe  = ref_link(k);
      e_lval = m_pc + 32'd8;
    end else begin
      e_pc = m_pc; e_npc = m_npc; e_lwe = 1'b0; e_lval = '0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "fetch_pc", fetch_pc, e_pc);
    chk(tag, "next_pc", next_pc, e_npc);
    chk(tag, "link_we", {31'd0, link_we}, {31'd0, e_lwe});
    if (e_lwe) begin
      chk(tag, "link_val", link_val, e_lval);
      chk(tag, "link_idx", {27'd0, link_idx}, 32'd31);
    end
    m_pc = e_pc;
    m_npc = e_npc;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "fetch_pc", fetch_pc, RV);
    chk("R1", "next_pc", next_pc, RV + 32'd4);
    chk("R1", "link_we", {31'd0, link_we}, 32'd0);
    rst = 1'b0;
    m_pc = RV; m_npc = RV + 32'd4;

    run_instr(4'd0, 0, 0, 0, 0, 0, 1'b1, "R2");
    run_instr(4'd1, 5, 5, 16'h0010, 0, 0, 1'b0, "R11");       // idle: nothing moves
    run_instr(4'd1, 5, 5, 16'h0010, 0, 0, 1'b1, "R3");        // taken: slot first
    run_instr(4'd0, 0, 0, 0, 0, 0, 1'b1, "R3");               // then target
    run_instr(4'd2, 7, 7, 16'h0040, 0, 0, 1'b1, "R4");        // not taken
    run_instr(4'd3, 0, 1, 16'h0004, 0, 0, 1'b1, "R6");        // <=0 with 0: taken
    run_instr(4'd4, 0, 1, 16'h0004, 0, 0, 1'b1, "R6");        // >0 with 0: not
    run_instr(4'd5, 32'h8000_0000, 0, 16'h0008, 0, 0, 1'b1, "R6");
    run_instr(4'd6, 32'hFFFF_FFFF, 0, 16'h0008, 0, 0, 1'b1, "R6");
    run_instr(4'd1, 3, 3, 16'hFFF0, 0, 0, 1'b1, "R3");        // negative offset
    run_instr(4'd9, 0, 0, 0, 26'h2ABCDEF, 0, 1'b1, "R7");
    run_instr(4'd11, 0, 0, 0, 0, 32'hF000_2468, 1'b1, "R8");
    run_instr(4'd10, 0, 0, 0, 26'h3000001, 0, 1'b1, "R7");    // high upper bits
    run_instr(4'd7, 5, 0, 16'h0100, 0, 0, 1'b1, "R9");        // link, not taken
    run_instr(4'd8, 5, 0, 16'h0100, 0, 0, 1'b1, "R9");        // link, taken
    run_instr(4'd13, 4, 4, 16'h0100, 26'h1, 32'h10, 1'b1, "R10");
    run_instr(4'd15, 4, 4, 16'h0100, 26'h1, 32'h10, 1'b1, "R10");
    run_instr(4'd0, 0, 0, 0, 0, 0, 1'b0, "R11");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  k;
      logic [31:0] a, b;
      bit          s;
      k = 4'($urandom_range(0, 15));
      a = $urandom();
      case ($urandom_range(0, 3))
        0: a = '0;
        1: a = 32'h8000_0000;
        default: ;
      endcase
      b = ($urandom_range(0, 1) == 0) ? a : $urandom();
      s = ($urandom_range(0, 4) != 0);
      run_instr(k, a, b, 16'($urandom()), 26'($urandom()), $urandom(), s,
                s ? tag_of(k) : "R11");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule